// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds a stored operand into an accumulator one bit per clock. Two shift registers of `WIDTH` bits (default 4) are held inside: the accumulator and the operand register. An addition moves both registers one place toward the least significant end on every clock. Their low bits feed a single full adder. The sum bit enters the accumulator at its most significant end, and the carry waits in a flip-flop until the next bit.

After `WIDTH` clocks the accumulator holds the sum modulo 2^WIDTH, and the carry flip-flop holds the final carry. The operand register rotates rather than emptying, so its value survives the operation. Repeated start pulses therefore keep adding the same operand into the running total.

Software-free use is simple. Load the accumulator and the operand in parallel while idle, pulse start, and wait for the one-cycle done pulse. Load strobes and start pulses that arrive while an addition is running have no effect.

Top module: `serialAccumAdder`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator, the operand register, the carry flip-flop, busy and done at once, without waiting for a clock edge.
- R2: While idle, a high `loadAEn` at a rising edge copies `loadAVal` into the accumulator, and a high `loadBEn` copies `loadBVal` into the operand register. The two strobes act independently and may be high together.
- R3: While idle with no load strobe, the accumulator, the operand register and `carryOut` keep their values.
- R4: A start pulse while idle clears the carry flip-flop. `busy` is then high for exactly `WIDTH` clock cycles, starting at the next edge.
- R5: When busy falls, `sumOut` equals (A + B) mod 2^WIDTH and `carryOut` equals bit WIDTH of A + B. Here A and B are the values held when the addition started.
- R6: `done` is high for exactly one cycle, starting at the edge where `busy` falls.
- R7: The operand register is unchanged after an addition, so a further start adds the same B to the new accumulator value.
- R8: While busy, load strobes and start pulses are ignored. The result and the length of the busy phase are unaffected by them.
- R9: A load strobe in the same idle cycle as a start pulse is accepted, and the addition uses the freshly loaded value.
- R10: `carryOut` keeps the final carry after done until the next start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadAVal | input | WIDTH | Parallel value for the accumulator |
| loadAEn | input | 1 | Accumulator load strobe |
| loadBVal | input | WIDTH | Parallel value for the operand register |
| loadBEn | input | 1 | Operand register load strobe |
| startPulse | input | 1 | Begins an addition when idle |
| busy | output | 1 | High while shifting |
| done | output | 1 | One-cycle pulse at completion |
| sumOut | output | WIDTH | Accumulator contents |
| carryOut | output | 1 | Carry flip-flop contents |

## Verification
Two events can share a cycle in this block. The first is a parallel load coinciding with a start pulse while idle. The second is a load or start strobe arriving during a busy phase. The bench provokes both at random: it sets start and load strobes together at the launch edge, and it drives random load values and start pulses on every busy cycle. It judges them at the ports: launch-cycle loads must show in the sum, busy-time strobes must leave the sum, the busy length and the next accumulation untouched, and a leftover carry of one must be cleared by each start.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic clearCarry;
    logic shiftEn;
  } saddStrobe_t;
endpackage

// File: rtl/sadd_full_adder.sv
module sadd_full_adder (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  always_comb begin
    sBit = aBit ^ bBit ^ cIn;
    cOut = (aBit & bBit) | (aBit & cIn) | (bBit & cIn);
  end
endmodule

// File: rtl/sadd_datapath.sv
module sadd_datapath
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  saddStrobe_t      strobe,
  input  logic [WIDTH-1:0] loadAVal,
  input  logic [WIDTH-1:0] loadBVal,
  output logic [WIDTH-1:0] accQ,
  output logic             carryQ
);
  logic [WIDTH-1:0] operandQ;
  logic             sumBit;
  logic             carryNext;

  sadd_full_adder u_fa (
    .aBit(accQ[0]),
    .bBit(operandQ[0]),
    .cIn (carryQ),
    .sBit(sumBit),
    .cOut(carryNext)
  );

  // Accumulator: sum bit enters at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accQ <= '0;
    else if (strobe.shiftEn) accQ <= {sumBit, accQ[WIDTH-1:1]};
    else if (strobe.loadA) accQ <= loadAVal;
  end

  // Operand register rotates so it is preserved
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) operandQ <= '0;
    else if (strobe.shiftEn) operandQ <= {operandQ[0], operandQ[WIDTH-1:1]};
    else if (strobe.loadB) operandQ <= loadBVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carryQ <= 1'b0;
    else if (strobe.clearCarry) carryQ <= 1'b0;
    else if (strobe.shiftEn) carryQ <= carryNext;
  end

  // R7: rotation never changes how many ones the operand holds
  a_r7_operand_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> $countones(operandQ) == $past($countones(operandQ)));

  // R3: no shift and no load leaves the accumulator as it was
  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.shiftEn && !strobe.loadA) |=> $stable(accQ));

  // R4: a start leaves the carry cleared
  a_r4_carry_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCarry |=> !carryQ);
endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadAEn,
  input  logic        loadBEn,
  input  logic        startPulse,
  output saddStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (startPulse) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end
    end
  end

  always_comb begin
    strobe.loadA      = !busy && loadAEn;
    strobe.loadB      = !busy && loadBEn;
    strobe.clearCarry = !busy && startPulse;
    strobe.shiftEn    = busy;
  end

  // R6: done lasts one cycle and only follows a busy phase
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R8: while busy the count advances by one regardless of a new start
  a_r8_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitCnt != LAST) |=> (busy && bitCnt == $past(bitCnt) + 1'b1));

  // R4: a start while idle raises busy with a fresh count
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> (busy && bitCnt == '0));
endmodule

// File: rtl/serialAccumAdder.sv
module serialAccumAdder
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] loadAVal,
  input  logic             loadAEn,
  input  logic [WIDTH-1:0] loadBVal,
  input  logic             loadBEn,
  input  logic             startPulse,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  saddStrobe_t strobe;

  sadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadAEn   (loadAEn),
    .loadBEn   (loadBEn),
    .startPulse(startPulse),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  sadd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadAVal(loadAVal),
    .loadBVal(loadBVal),
    .accQ    (sumOut),
    .carryQ  (carryOut)
  );
endmodule

// File: tb/serialAccumAdder_bench.sv
module serialAccumAdder_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b1;
  logic [W-1:0] loadAVal = '0;
  logic         loadAEn = 1'b0;
  logic [W-1:0] loadBVal = '0;
  logic         loadBEn = 1'b0;
  logic         startPulse = 1'b0;
  logic         busy, done, carryOut;
  logic [W-1:0] sumOut;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] expA = '0;
  logic [W-1:0] expB = '0;
  logic         expC = 1'b0;

  always #5 clk = ~clk;

  serialAccumAdder #(.WIDTH(W)) u_serialAccumAdder (
    .clk(clk), .rstN(rstN), .loadAVal(loadAVal), .loadAEn(loadAEn),
    .loadBVal(loadBVal), .loadBEn(loadBEn), .startPulse(startPulse),
    .busy(busy), .done(done), .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic logic [W:0] addModel(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Launch an addition; optional loads with the start, optional noise while busy
  task automatic runAdd(input bit withLoadA, input bit withLoadB,
                        input logic [W-1:0] va, input logic [W-1:0] vb,
                        input bit noise);
    logic [W:0] full;
    @(negedge clk);
    startPulse = 1'b1;
    loadAEn = withLoadA; loadAVal = va;
    loadBEn = withLoadB; loadBVal = vb;
    if (withLoadA) expA = va;
    if (withLoadB) expB = vb;
    @(negedge clk);
    startPulse = 1'b0; loadAEn = 1'b0; loadBEn = 1'b0;
    chk("R4 busy after start", int'(busy), 1);
    chk("R4 carry cleared", int'(carryOut), 0);
    full = addModel(expA, expB);
    for (int i = 0; i < W; i++) begin
      if (i > 0) chk("R4 busy held", int'(busy), 1);
      if (noise) begin
        loadAEn = 1'($urandom); loadAVal = W'($urandom);
        loadBEn = 1'($urandom); loadBVal = W'($urandom);
        startPulse = 1'($urandom);
      end
      @(negedge clk);
    end
    loadAEn = 1'b0; loadBEn = 1'b0; startPulse = 1'b0;
    expA = full[W-1:0];
    expC = full[W];
    chk("R4 busy ends", int'(busy), 0);
    chk("R6 done pulse", int'(done), 1);
    chk(noise ? "R8 sum with noise" : (withLoadA || withLoadB) ? "R9 sum" : "R5 sum",
        int'(sumOut), int'(expA));
    chk("R5 carry", int'(carryOut), int'(expC));
    @(negedge clk);
    chk("R6 done falls", int'(done), 0);
    chk("R10 carry held", int'(carryOut), int'(expC));
    chk("R3 sum held", int'(sumOut), int'(expA));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0;
    #12;
    chk("R1 sum at reset", int'(sumOut), 0);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 carry at reset", int'(carryOut), 0);
    @(negedge clk); rstN = 1'b1;

    // R2: independent and joint loads
    @(negedge clk); loadAEn = 1'b1; loadAVal = 4'd9;
    @(negedge clk); loadAEn = 1'b0;
    chk("R2 load A", int'(sumOut), 9);
    @(negedge clk); loadBEn = 1'b1; loadBVal = 4'd7;
    @(negedge clk); loadBEn = 1'b0;
    expA = 4'd9; expB = 4'd7;
    chk("R2 B load leaves A", int'(sumOut), 9);
    repeat (3) @(negedge clk);
    chk("R3 idle hold", int'(sumOut), 9);

    // 9+7 = 16 -> sum 0 carry 1, then again to check carry clear and R7
    runAdd(1'b0, 1'b0, '0, '0, 1'b0);
    runAdd(1'b0, 1'b0, '0, '0, 1'b0);
    chk("R7 B reused", int'(sumOut), 7);

    // async reset mid-cycle, then B must read as zero
    @(negedge clk); #2 rstN = 1'b0; #1;
    chk("R1 async clear", int'(sumOut), 0);
    @(negedge clk); rstN = 1'b1;
    expA = '0; expB = '0; expC = 1'b0;
    runAdd(1'b1, 1'b0, 4'd15, '0, 1'b0);
    chk("R1 B cleared", int'(sumOut), 15);

    // corner cases: max + max, max + 1
    runAdd(1'b1, 1'b1, 4'd15, 4'd15, 1'b1);
    runAdd(1'b1, 1'b1, 4'd15, 4'd1, 1'b0);
    runAdd(1'b0, 1'b0, '0, '0, 1'b1);

    for (int k = 0; k < 40; k++) begin
      runAdd(1'($urandom), 1'($urandom), W'($urandom), W'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) begin
        @(negedge clk); loadBEn = 1'b1; loadBVal = W'($urandom); expB = loadBVal;
        @(negedge clk); loadBEn = 1'b0;
        chk("R2 B load idle", int'(sumOut), int'(expA));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule